// File: doc/BRIEF.md
# RFID Reader Front-End Control Sequencer

This block is the digital sequencer of a low-frequency RFID reader front end. It runs on a clock taken from the carrier oscillator at twice the carrier rate and makes the carrier square wave by toggling a phase flop. A host drives three inputs: a sleep request, a modulation (field-stop) request and a short-circuit flag from the driver protection. From these the block decides when the antenna drivers are biased and when they are tri-stated. It freezes the oscillator and demodulator operating points around a field stop. It also drives a ready line that carries the carrier waveform once the receive chain has settled.

The sleep and modulation requests are brought into the carrier domain through two-flop synchronisers. When sleep is released, the block turns the field on and waits a settling interval with the ready line released (output enable low, level low). It then enters the running state, where the ready line is driven with the carrier. A modulation request in the running state tri-states the drivers at the start of a carrier period and holds the oscillator and demodulator. The hold is released a fixed number of carrier periods after the drivers come back. A short-circuit flag latches a fault that only a new sleep request clears.

Top module: `rfid_fe_seq`

## Requirements
- R1: After reset, and whenever the synchronised sleep request is high, `field_en`, `ant_oe`, `ant_wave` and `demod_hold` are 0, `rdy_oe` is 1 and `rdy_out` is 0.
- R2: `sleep_req` and `mod_req` each pass two synchroniser flops. A change of `sleep_req` sampled at one rising edge changes the sequencer state at the third rising edge.
- R3: When sleep is released, the block enters a settling phase that lasts exactly `SETTLE_CYC` clock cycles. In that phase `field_en` and `ant_oe` are 1, while `rdy_oe` and `rdy_out` are 0.
- R4: In the running state, `rdy_oe` is 1 and `rdy_out` equals `ant_wave` on every cycle.
- R5: While `field_en` is 1, `ant_wave` inverts on every clock cycle, so one carrier period is two clock cycles, and its first cycle after field turn-on is 0. While `field_en` is 0, `ant_wave` is 0.
- R6: In the running state, `ant_oe` follows the synchronised modulation request (`ant_oe` = 0 while it is high). It changes only at the edge where `ant_wave` goes from 1 to 0, i.e. at the start of a carrier period.
- R7: `demod_hold` is 1 whenever the drivers are tri-stated in the running state. It stays 1 for exactly 2·`RELEASE_PERIODS` clock cycles (41 carrier periods by default) after `ant_oe` returns to 1.
- R8: A new field stop that begins while the hold is still being released restarts the release count from zero.
- R9: `rdy_out` keeps toggling with the carrier while the drivers are tri-stated for modulation.
- R10: `short_det` high at a rising edge in the settling or running state enters the fault state at that edge. In the fault state `field_en`, `ant_oe`, `ant_wave` and `demod_hold` are 0, `rdy_oe` is 1 and `rdy_out` is 0.
- R11: `mod_req` has no effect on any output during the settling phase or the fault state.
- R12: The fault state holds, whatever `short_det` does, until the synchronised sleep request goes high. The block then sleeps and goes through a full settling phase again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock at twice the carrier rate |
| rst | input | 1 | Synchronous active-high reset |
| sleep_req | input | 1 | Sleep request, asynchronous to `clk` |
| mod_req | input | 1 | Field-stop request, asynchronous to `clk` |
| short_det | input | 1 | Driver short-circuit flag, synchronous to `clk` |
| field_en | output | 1 | Antenna driver bias enable |
| ant_oe | output | 1 | Driver output enable (0 = tri-state) |
| ant_wave | output | 1 | Carrier waveform for the drivers |
| demod_hold | output | 1 | Freeze of oscillator and demodulator operating points |
| rdy_out | output | 1 | Ready line level (carrier when running) |
| rdy_oe | output | 1 | Ready line drive enable (0 = weak pull-down only) |

## Verification
The assertions assume that `short_det` is already synchronous to the oscillator clock and that reset is applied for at least one edge before any check. They also assume that the sleep and modulation requests stay stable long enough for the two-flop synchronisers to settle. The stimulus changes every input only on the falling clock edge, holds each request for several cycles, and pulses `short_det` for one full cycle. Field stops have odd and even lengths so that both carrier phases are hit. The bench also starts a second stop inside the release window and raises modulation during settling and during a fault.

// File: rtl/rfid_seq_pkg.sv
package rfid_seq_pkg;

    typedef enum logic [1:0] {
        ST_SLEEP  = 2'd0,
        ST_SETTLE = 2'd1,
        ST_RUN    = 2'd2,
        ST_FAULT  = 2'd3
    } seq_state_e;

    typedef struct packed {
        logic field_en;
        logic ant_oe;
        logic ant_wave;
        logic demod_hold;
        logic rdy_out;
        logic rdy_oe;
    } fe_out_s;

    // Field is radiated in settling and running states.
    function automatic logic field_live(seq_state_e s);
        return (s == ST_SETTLE) || (s == ST_RUN);
    endfunction

endpackage

// File: rtl/rfid_seq_sync.sv
module rfid_seq_sync #(
    parameter int          W       = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic st1_q, st2_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                st1_q <= RST_VAL[i];
                st2_q <= RST_VAL[i];
            end else begin
                st1_q <= din[i];
                st2_q <= st1_q;
            end
        end
        assign dout[i] = st2_q;
    end
endmodule

// File: rtl/rfid_seq_fsm.sv
module rfid_seq_fsm
    import rfid_seq_pkg::*;
#(
    parameter int SETTLE_CYC = 6250
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sleep_s,
    input  logic       short_det,
    output seq_state_e state_q
);
    localparam int SCW = $clog2(SETTLE_CYC + 1);
    localparam logic [SCW-1:0] SETTLE_LAST = SCW'(SETTLE_CYC - 1);

    seq_state_e     state_d;
    logic [SCW-1:0] scnt_q;

    always_comb begin
        state_d = state_q;
        if (sleep_s) begin
            state_d = ST_SLEEP;
        end else begin
            unique case (state_q)
                ST_SLEEP:  state_d = ST_SETTLE;
                ST_SETTLE: state_d = short_det ? ST_FAULT :
                                     (scnt_q == SETTLE_LAST) ? ST_RUN : ST_SETTLE;
                ST_RUN:    state_d = short_det ? ST_FAULT : ST_RUN;
                ST_FAULT:  state_d = ST_FAULT;
                default:   state_d = ST_SLEEP;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_SLEEP;
            scnt_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_SETTLE && state_d == ST_SETTLE)
                scnt_q <= scnt_q + 1'b1;
            else
                scnt_q <= '0;
        end
    end

    a_r3_settle_bound: assert property (@(posedge clk) disable iff (rst)
        scnt_q < SCW'(SETTLE_CYC));

    a_r12_fault_latched: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_FAULT && !sleep_s) |=> (state_q == ST_FAULT));

    a_r1_sleep_wins: assert property (@(posedge clk) disable iff (rst)
        sleep_s |=> (state_q == ST_SLEEP));
endmodule

// File: rtl/rfid_seq_gap.sv
module rfid_seq_gap #(
    parameter int RELEASE_PERIODS = 41
) (
    input  logic clk,
    input  logic rst,
    input  logic live,
    input  logic run,
    input  logic mod_s,
    output logic car_q,
    output logic gap_q,
    output logic hold_out
);
    localparam int REL_CYC = 2 * RELEASE_PERIODS;
    localparam int HCW     = $clog2(REL_CYC + 1);
    localparam logic [HCW-1:0] REL_LAST = HCW'(REL_CYC - 1);

    logic           hold_q;
    logic [HCW-1:0] hcnt_q;

    // Carrier phase: two clock cycles per carrier period.
    always_ff @(posedge clk) begin
        if (rst || !live) car_q <= 1'b0;
        else              car_q <= ~car_q;
    end

    // Field stop only updates at the end of a carrier period.
    always_ff @(posedge clk) begin
        if (rst || !run) gap_q <= 1'b0;
        else if (car_q)  gap_q <= mod_s;
    end

    // Release counter restarts whenever a stop is active.
    always_ff @(posedge clk) begin
        if (rst || !run) begin
            hold_q <= 1'b0;
            hcnt_q <= '0;
        end else if (gap_q) begin
            hold_q <= 1'b1;
            hcnt_q <= '0;
        end else if (hold_q) begin
            if (hcnt_q == REL_LAST) begin
                hold_q <= 1'b0;
                hcnt_q <= '0;
            end else begin
                hcnt_q <= hcnt_q + 1'b1;
            end
        end
    end

    assign hold_out = (hold_q || gap_q) && run;

    a_r6_gap_on_period_start: assert property (@(posedge clk) disable iff (rst)
        (run && $past(run) && (gap_q != $past(gap_q))) |-> (!car_q && $past(car_q)));

    a_r5_carrier_toggles: assert property (@(posedge clk) disable iff (rst)
        (live && $past(live)) |-> (car_q != $past(car_q)));

    a_r7_hold_after_stop: assert property (@(posedge clk) disable iff (rst)
        (run && $past(run) && $fell(gap_q)) |-> hold_out);

    a_r8_release_bound: assert property (@(posedge clk) disable iff (rst)
        hcnt_q < HCW'(REL_CYC));
endmodule

// File: rtl/rfid_fe_seq.sv
module rfid_fe_seq
    import rfid_seq_pkg::*;
#(
    parameter int SETTLE_CYC      = 6250,
    parameter int RELEASE_PERIODS = 41
) (
    input  logic clk,
    input  logic rst,
    input  logic sleep_req,
    input  logic mod_req,
    input  logic short_det,
    output logic field_en,
    output logic ant_oe,
    output logic ant_wave,
    output logic demod_hold,
    output logic rdy_out,
    output logic rdy_oe
);
    seq_state_e state_q;
    logic [1:0] req_s;
    logic       live, run, car_q, gap_q, hold_w;
    fe_out_s    o;

    rfid_seq_sync #(.W(2), .RST_VAL(2'b01)) u_sync (
        .clk(clk), .rst(rst), .din({mod_req, sleep_req}), .dout(req_s)
    );

    rfid_seq_fsm #(.SETTLE_CYC(SETTLE_CYC)) u_fsm (
        .clk(clk), .rst(rst), .sleep_s(req_s[0]), .short_det(short_det),
        .state_q(state_q)
    );

    assign live = field_live(state_q);
    assign run  = (state_q == ST_RUN);

    rfid_seq_gap #(.RELEASE_PERIODS(RELEASE_PERIODS)) u_gap (
        .clk(clk), .rst(rst), .live(live), .run(run), .mod_s(req_s[1]),
        .car_q(car_q), .gap_q(gap_q), .hold_out(hold_w)
    );

    always_comb begin
        o.field_en   = live;
        o.ant_wave   = car_q && live;
        o.ant_oe     = live && !gap_q;
        o.demod_hold = hold_w;
        o.rdy_oe     = (state_q != ST_SETTLE);
        o.rdy_out    = run && car_q;
    end

    assign field_en   = o.field_en;
    assign ant_oe     = o.ant_oe;
    assign ant_wave   = o.ant_wave;
    assign demod_hold = o.demod_hold;
    assign rdy_out    = o.rdy_out;
    assign rdy_oe     = o.rdy_oe;

    a_r10_fault_quiet: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_FAULT) |-> (!ant_oe && !demod_hold && rdy_oe && !rdy_out));

    a_r9_rdy_runs_in_gap: assert property (@(posedge clk) disable iff (rst)
        (run && $past(run) && !ant_oe) |-> (rdy_out != $past(rdy_out)));
endmodule

// File: tb/rfid_fe_seq_tb.sv
module rfid_fe_seq_tb_top;
    localparam int SETTLE = 20;
    localparam int REL    = 82;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sleep_req = 1'b1, mod_req = 1'b0, short_det = 1'b0;
    logic field_en, ant_oe, ant_wave, demod_hold, rdy_out, rdy_oe;

    always #4 clk = ~clk;

    rfid_fe_seq #(.SETTLE_CYC(SETTLE), .RELEASE_PERIODS(41)) dut_i (
        .clk(clk), .rst(rst), .sleep_req(sleep_req), .mod_req(mod_req),
        .short_det(short_det), .field_en(field_en), .ant_oe(ant_oe),
        .ant_wave(ant_wave), .demod_hold(demod_hold), .rdy_out(rdy_out),
        .rdy_oe(rdy_oe)
    );

    int n_chk = 0, n_bad = 0, cyc_cnt = 0;
    string tag = "R1";
    bit done = 0;

    // Behavioural model: 0 sleep, 1 settle, 2 run, 3 fault
    int s1, s2, m1, m2, mst, scnt, car, gap, hold, hcnt;

    always @(posedge clk) begin
        if (rst) begin
            s1 = 1; s2 = 1; m1 = 0; m2 = 0; mst = 0; scnt = 0;
            car = 0; gap = 0; hold = 0; hcnt = 0;
        end else begin
            int n_st, n_scnt, n_car, n_gap, n_hold, n_hcnt;
            bit live, run;
            live = (mst == 1 || mst == 2);
            run  = (mst == 2);
            if (s2 != 0) n_st = 0;
            else if (mst == 0) n_st = 1;
            else if (mst == 1) n_st = short_det ? 3 : (scnt == SETTLE - 1 ? 2 : 1);
            else if (mst == 2) n_st = short_det ? 3 : 2;
            else n_st = 3;
            n_scnt = (mst == 1 && n_st == 1) ? scnt + 1 : 0;
            n_car  = live ? (car == 0 ? 1 : 0) : 0;
            n_gap  = !run ? 0 : (car != 0 ? m2 : gap);
            n_hold = hold; n_hcnt = hcnt;
            if (!run) begin n_hold = 0; n_hcnt = 0; end
            else if (gap != 0) begin n_hold = 1; n_hcnt = 0; end
            else if (hold != 0) begin
                if (hcnt == REL - 1) begin n_hold = 0; n_hcnt = 0; end
                else n_hcnt = hcnt + 1;
            end
            s2 = s1; s1 = sleep_req; m2 = m1; m1 = mod_req;
            mst = n_st; scnt = n_scnt; car = n_car; gap = n_gap;
            hold = n_hold; hcnt = n_hcnt;
        end
    end

    task automatic chk(string name, logic act, bit exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s act=%b exp=%b t=%0t", tag, name, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !done) begin
            bit live;
            live = (mst == 1 || mst == 2);
            chk("field_en", field_en, live);
            chk("ant_wave", ant_wave, live && car != 0);
            chk("ant_oe", ant_oe, live && gap == 0);
            chk("demod_hold", demod_hold, (mst == 2) && (hold != 0 || gap != 0));
            chk("rdy_oe", rdy_oe, mst != 1);
            chk("rdy_out", rdy_out, (mst == 2) && car != 0);
        end
    end

    always @(posedge clk) begin
        cyc_cnt++;
        if (cyc_cnt > 150000 && !done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    task automatic wait_cyc(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        wait_cyc(4);
        rst = 1'b0;
        tag = "R1"; wait_cyc(6);                       // reset and sleep state
        tag = "R2"; sleep_req = 1'b0; wait_cyc(3);    // synchroniser latency
        tag = "R11"; mod_req = 1'b1; wait_cyc(6);     // ignored in settling
        mod_req = 1'b0;
        tag = "R3"; wait_cyc(SETTLE);
        tag = "R4"; wait_cyc(10);
        tag = "R6"; mod_req = 1'b1; wait_cyc(7);      // odd-length stop
        tag = "R9"; wait_cyc(4);
        mod_req = 1'b0;
        tag = "R7"; wait_cyc(REL + 10);
        tag = "R6"; wait_cyc(1); mod_req = 1'b1; wait_cyc(10);
        mod_req = 1'b0;
        tag = "R8"; wait_cyc(30); mod_req = 1'b1; wait_cyc(4);
        mod_req = 1'b0; wait_cyc(REL + 10);
        tag = "R10"; mod_req = 1'b1; wait_cyc(3);
        short_det = 1'b1; wait_cyc(1); short_det = 1'b0;
        wait_cyc(5);
        tag = "R11"; mod_req = 1'b0; wait_cyc(4); mod_req = 1'b1; wait_cyc(6);
        mod_req = 1'b0;
        tag = "R12"; wait_cyc(20);
        sleep_req = 1'b1; wait_cyc(6);
        sleep_req = 1'b0; wait_cyc(SETTLE + 15);
        tag = "R5"; sleep_req = 1'b1; wait_cyc(5);
        sleep_req = 1'b0; wait_cyc(8);
        tag = "R10"; short_det = 1'b1; wait_cyc(1); short_det = 1'b0;
        wait_cyc(SETTLE + 5);
        tag = "R1"; sleep_req = 1'b1; wait_cyc(8);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule